// File: doc/BRIEF.md
# Sequential Signed/Unsigned Integer Divider

This block is a multi-cycle integer divider for the execute stage of a simple in-order processor. The stage pulses `start` once. With that pulse it supplies the dividend, the divisor and a mode bit that selects signed or unsigned division. In signed mode the block takes the absolute value of each negative operand. It then runs a restoring division on the unsigned magnitudes and finds one quotient bit per clock. At the end it applies signs to the quotient and remainder in two's complement form.

`busy` stays high from the cycle after an accepted start until the result is delivered, and the pipeline uses it as a stall. `done` is a one-cycle pulse. The results stay on `quotient` and `remainder` until the next accepted start. Division by zero raises no exception: it finishes quickly and returns fixed values.

Top module: `seq_divider`

## Requirements
- R1: With `is_signed`=0, the operands are unsigned W-bit values. `quotient` is the floor of dividend/divisor and `remainder` is dividend mod divisor (for example 0xFFFFFFF1/0x11 gives 0x0F0F0F0E remainder 3).
- R2: With `is_signed`=1, both operands are two's complement and the quotient is truncated toward zero. The quotient is negative exactly when the operand sign bits (bit W-1) differ (for example -10/5 gives 0xFFFFFFFE and -10/-5 gives 2).
- R3: In signed mode the remainder has the sign of the dividend, whatever the sign of the divisor (for example -7/2 gives remainder 0xFFFFFFFF and 7/-2 gives remainder 1).
- R4: For a nonzero divisor, `done` is high for exactly one cycle. That cycle starts W+1 rising edges after the edge that accepted `start`, counting the accepting edge as the first.
- R5: `busy` is low after reset. It is high from the edge that accepts `start` until the edge that ends the `done` cycle, and `done` is never high while `busy` is low.
- R6: A `start` pulse seen while `busy` is high is ignored. The division in progress keeps its result and its timing.
- R7: A zero divisor, in either mode, gives `done` one cycle after the accepting edge, `quotient` = all ones and `remainder` = the dividend exactly as it was given.
- R8: `quotient` and `remainder` keep their values from the `done` cycle until the next accepted `start`.
- R9: Signed 0x80000000 / 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R10: After reset, `quotient`, `remainder`, `busy` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse, accepted only when not busy |
| is_signed | input | 1 | 1 = signed division, 0 = unsigned division |
| dividend | input | W | Dividend operand |
| divisor | input | W | Divisor operand |
| busy | output | 1 | Pipeline stall, high while a division is in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W | Quotient, held until the next start |
| remainder | output | W | Remainder, held until the next start |

## Verification
The accumulator shifts one bit per step. A wrong trial-subtract decision or a misplaced shift therefore corrupts every later quotient bit, and the damage shows in the values latched with the `done` pulse W+1 cycles after start. A wrong iteration count shows as `done` arriving early or late against the expected cycle. A sign flag captured wrongly shows only when the signs of the operands differ, so the operand sets cover all four sign combinations, the most negative value and a zero divisor. A start that the block should have ignored but accepted shows as a changed result or a shifted `done` cycle.

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  typedef enum logic [1:0] {S_IDLE, S_CALC, S_DONE} st_t;

  st_t           st;
  logic [W-1:0]  acc, rem, dvs;
  logic [CW-1:0] cnt;
  logic          neg_q, neg_r;

  wire           a_neg  = is_signed & dividend[W-1];
  wire           b_neg  = is_signed & divisor[W-1];
  wire [W-1:0]   a_mag  = a_neg ? -dividend : dividend;
  wire [W-1:0]   b_mag  = b_neg ? -divisor : divisor;
  wire           accept = start && (st == S_IDLE);

  wire [W:0]     shifted = {rem, acc[W-1]};
  wire [W:0]     trial   = shifted - {1'b0, dvs};
  wire           fits    = ~trial[W];

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign quotient  = neg_q ? -acc : acc;
  assign remainder = neg_r ? -rem : rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      acc   <= '0;
      rem   <= '0;
      dvs   <= '0;
      cnt   <= '0;
      neg_q <= 1'b0;
      neg_r <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          cnt <= '0;
          dvs <= b_mag;
          if (divisor == '0) begin
            acc   <= '1;
            rem   <= dividend;
            neg_q <= 1'b0;
            neg_r <= 1'b0;
            st    <= S_DONE;
          end else begin
            acc   <= a_mag;
            rem   <= '0;
            neg_q <= a_neg ^ b_neg;
            neg_r <= a_neg;
            st    <= S_CALC;
          end
        end
        S_CALC: begin
          rem <= fits ? trial[W-1:0] : shifted[W-1:0];
          acc <= {acc[W-2:0], fits};
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R4
  AST_START_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);  // R5
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);  // R5
  AST_ZERO_DIV_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor == '0) |=> (done && quotient == '1));  // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder)));  // R8
  AST_CALC_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);  // R6
endmodule

// File: tb/seq_divider_bench.sv
module seq_divider_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         is_signed = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done;
  logic [W-1:0] quotient, remainder;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [W-1:0] last_q, last_r;

  logic [W-1:0] sb_q[$];
  logic [W-1:0] sb_r[$];
  int           sb_c0[$];
  int           sb_lat[$];
  string        sb_tag[$];

  seq_divider #(.W(W)) u_seq_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input string tag, input logic sg, input logic [W-1:0] a,
                       input logic [W-1:0] b, input bit poke);
    logic [W-1:0] eq, er;
    longint sa, sbv;
    if (b == '0) begin
      eq = '1; er = a;
    end else if (sg) begin
      sa = longint'($signed(a)); sbv = longint'($signed(b));
      eq = W'(sa / sbv); er = W'(sa % sbv);
    end else begin
      eq = a / b; er = a % b;
    end
    @(negedge clk);
    start = 1'b1; is_signed = sg; dividend = a; divisor = b;
    sb_q.push_back(eq); sb_r.push_back(er); sb_c0.push_back(cyc);
    sb_lat.push_back(b == '0 ? 1 : W + 1); sb_tag.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    check("R5 busy after start", W'(busy), W'(1));
    if (poke && !done) begin
      start = 1'b1; is_signed = ~sg; dividend = 32'd99; divisor = 32'd3;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    check("R5 busy low after done", W'(busy), W'(0));
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R6 unexpected done actual=1 expected=0");
      end else begin
        check({sb_tag[0], " quotient"}, quotient, sb_q[0]);
        check({sb_tag[0], " remainder"}, remainder, sb_r[0]);
        check("R4 latency", W'(cyc - sb_c0[0]), W'(sb_lat[0]));
        last_q = quotient; last_r = remainder;
        void'(sb_q.pop_front()); void'(sb_r.pop_front()); void'(sb_c0.pop_front());
        void'(sb_lat.pop_front()); void'(sb_tag.pop_front());
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check("R10 quotient", quotient, '0);
        check("R10 remainder", remainder, '0);
        check("R10 busy/done", W'({busy, done}), W'(0));
        rst_n = 1'b1;
        issue("R1 100/7", 1'b0, 32'd100, 32'd7, 0);
        issue("R1 F1/11", 1'b0, 32'hFFFFFFF1, 32'h11, 0);
        issue("R1 5/9", 1'b0, 32'd5, 32'd9, 0);
        issue("R1 max/1", 1'b0, 32'hFFFFFFFF, 32'd1, 0);
        issue("R2 -10/5", 1'b1, -32'sd10, 32'd5, 0);
        issue("R2 -10/-5", 1'b1, -32'sd10, -32'sd5, 0);
        issue("R2 10/5", 1'b1, 32'd10, 32'd5, 0);
        issue("R2 10/-5", 1'b1, 32'd10, -32'sd5, 0);
        issue("R3 F1/11", 1'b1, 32'hFFFFFFF1, 32'h11, 0);
        issue("R2 11/F1", 1'b1, 32'h11, 32'hFFFFFFF1, 0);
        issue("R3 -7/2", 1'b1, -32'sd7, 32'd2, 0);
        issue("R3 7/-2", 1'b1, 32'd7, -32'sd2, 0);
        issue("R9 min/-1", 1'b1, 32'h80000000, 32'hFFFFFFFF, 0);
        issue("R7 signed/0", 1'b1, -32'sd10, 32'd0, 0);
        issue("R7 unsigned/0", 1'b0, 32'h12345678, 32'd0, 0);
        issue("R6 ignored start", 1'b0, 32'd1000, 32'd9, 1);
        repeat (4) @(negedge clk);
        check("R8 quotient held", quotient, 32'd111);
        check("R8 remainder held", remainder, 32'd1);
        check("R8 scoreboard empty", W'(sb_q.size()), W'(0));
      end
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule